// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port for a small microcontroller. Software reaches two registers over a simple register bus: an output latch that holds the value to drive, and a direction register whose bits choose, pin by pin, whether the pin is an input (bit set) or an output (bit clear). Both registers come out of reset as all ones, so every pin starts as a released input. Direction can be changed at any time by a bus write.

Per pin, the block produces a drive value, a drive enable and a pull-up enable for the pad cell. An open-drain flag per pin, supplied as static configuration, turns an output from push-pull into a pin that only ever pulls low. A pull-up configuration input decides which pins may have their pull-up on. It is applied only while the pin is an input.

Pad levels are passed through a two-stage synchronizer. The synchronized value feeds the read path and a change detector. A read of the latch address returns the synchronized pad level for input pins and the latch content for output pins. When the synchronized level of any input pin changes, a one-cycle wake-up pulse is raised.

Top module: `gpio_port`

## Requirements
- R1: While reset is low and at the first edge after it, the output latch and the direction register are all ones: no pin is driven (`pad_oe` = 0), and reading address 0 returns the synchronized pad levels.
- R2: A write with `bus_we` high takes effect at the rising edge that samples it. Address 0 (`bus_addr` = 0) selects the output latch and address 1 selects the direction register. Reading address 1 returns the direction register.
- R3: For a pin whose direction bit is 1, bit i of a read at address 0 is the pad level. A pad change applied before edge k is visible after edge k+1.
- R4: For a pin whose direction bit is 0, bit i of a read at address 0 is the latch bit. The pad level is ignored.
- R5: With the open-drain flag clear, `pad_oe[i]` is the inverse of the direction bit and `pad_out[i]` equals the latch bit.
- R6: With the open-drain flag set, `pad_out[i]` is 0, and `pad_oe[i]` is 1 only when the direction bit is 0 and the latch bit is 0.
- R7: `pad_pu[i]` is 1 only when the pull-up configuration bit is 1 and the pin is an input; an output pin never has its pull-up on.
- R8: `wake` is high for exactly one cycle, after edge k+1, when the pad level of an input pin changes before edge k. Level changes on output pins raise no wake-up.
- R9: With `bus_we` low, neither register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 1 | Register select: 0 latch, 1 direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| od_cfg | input | 8 | Open-drain flag per pin |
| pu_cfg | input | 8 | Pull-up permitted per pin |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad drive enable |
| pad_pu | output | 8 | Pad pull-up enable |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
Pad controls and read data respond combinationally to register state. A register write is therefore visible one edge after the strobe is sampled. A pad change reaches the read data and the wake pulse two edges after it is applied, and the pulse falls again one edge later. Each stimulus in the bench pushes its expected values with a due cycle counted from the edge that follows it. The monitor compares them just after that edge, so a result that is a cycle early or late fails. Wake is checked both in the cycle it is due and in the cycle after, to catch a stretched pulse.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port.
// Assumes a one-bit register address on the bus.
package gpio_port_pkg;
    typedef enum logic {
        REG_LATCH = 1'b0,
        REG_DIR   = 1'b1
    } gpio_reg_e;
endpackage

// File: rtl/gpio_port_regs.sv
// Output latch and direction register of the port.
// Assumes a single-cycle write strobe sampled at the rising edge.
// Both registers reset to all ones, so every pin starts as an input.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    // Update the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            dir_q   <= '1;
        end else if (we) begin
            if (gpio_reg_e'(addr) == REG_LATCH) latch_q <= wdata;
            else                                dir_q   <= wdata;
        end
    end
endmodule

// File: rtl/gpio_port_insync.sv
// Pad input synchronizer with a change detector.
// Assumes pad levels are asynchronous to clk.
// The synchronizer depth is set by STAGES, which must be at least 2.
// Wake-up is raised for one cycle when the synchronized level of an input pin changes.
module gpio_port_insync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] dir,
    output logic [W-1:0] sync_o,
    output logic         wake_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    // First stage samples the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '1;
        else        stage_q[0] <= pad_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage retimes the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    // Keep the previous synchronized value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= stage_q[LAST];
    end

    assign sync_o = stage_q[LAST];

    // Raise the pulse when any input pin has a changed level.
    always_comb begin
        wake_o = |((stage_q[LAST] ^ prev_q) & dir);
    end
endmodule

// File: rtl/gpio_port_drive.sv
// Pad drive and pull-up control, one slice per pin.
// Assumes a direction bit of 1 means input.
// In open-drain mode the pad is only ever pulled low.
module gpio_port_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] od_cfg,
    input  logic [W-1:0] pu_cfg,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            // Choose the drive style for this pin.
            always_comb begin
                if (od_cfg[i]) begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = ~dir[i] & ~latch[i];
                end else begin
                    pad_out[i] = latch[i];
                    pad_oe[i]  = ~dir[i];
                end
                pad_pu[i] = pu_cfg[i] & dir[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port: register bank, input synchronizer, pad control and read mux.
// Assumes a synchronous active-low reset and a combinational read path.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] od_cfg,
    input  logic [W-1:0] pu_cfg,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic         wake
);
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] sync_in;

    gpio_port_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_port_insync #(.W(W), .STAGES(STAGES)) u_insync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .dir    (dir_q),
        .sync_o (sync_in),
        .wake_o (wake)
    );

    gpio_port_drive #(.W(W)) u_drive (
        .latch   (latch_q),
        .dir     (dir_q),
        .od_cfg  (od_cfg),
        .pu_cfg  (pu_cfg),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // Read mux: input pins show the pad, output pins show the latch.
    always_comb begin
        if (gpio_reg_e'(bus_addr) == REG_DIR) bus_rdata = dir_q;
        else bus_rdata = (sync_in & dir_q) | (latch_q & ~dir_q);
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for the GPIO port, bound to every gpio_port instance.
// Assumes the register names latch_q and dir_q inside the top.
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input logic         bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] od_cfg,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] dir_q
);
    // R1
    reset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_q == '1 && dir_q == '1));

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr) |=> (latch_q == $past(bus_wdata)));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr) |=> (dir_q == $past(bus_wdata)));

    // R9
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(latch_q) && $stable(dir_q)));

    // R4
    out_pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> (((bus_rdata ^ latch_q) & ~dir_q) == '0));

    // R6
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & od_cfg) == '0);

    // R7
    no_pullup_on_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~dir_q) == '0);
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .od_cfg    (od_cfg),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .latch_q   (latch_q),
    .dir_q     (dir_q)
);

// File: tb/gpio_port_bench.sv
// Scoreboard bench for gpio_port: the driver pushes expected items with a due cycle,
// and the monitor compares them just after the matching rising edge.
module gpio_port_bench;
    localparam int W = 8;
    localparam int K_RDATA = 0, K_OE = 1, K_OUT = 2, K_PU = 3, K_WAKE = 4;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_addr = 1'b0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] od_cfg = '0;
    logic [W-1:0] pu_cfg = 8'h0F;
    logic [W-1:0] pad_in = 8'hFF;
    logic [W-1:0] pad_out, pad_oe, pad_pu;
    logic         wake;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];

    gpio_port #(.W(W)) u_gpio_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .od_cfg    (od_cfg),
        .pu_cfg    (pu_cfg),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .wake      (wake)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Push one expected item, due d edges from now.
    task automatic expect_at(input int kind, input logic [7:0] exp, input int d, input string req);
        item_t it;
        it.due = cyc + d; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Write one register, holding the strobe for one edge.
    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Let n cycles pass.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare the items that are due just after each edge.
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RDATA: act = bus_rdata;
                K_OE:    act = pad_oe;
                K_OUT:   act = pad_out;
                K_PU:    act = pad_pu;
                default: act = {7'd0, wake};
            endcase
            checks++;
            if (it.due != cyc || act !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d cycle %0d: actual %h expected %h", it.req, it.kind, cyc, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        idle(4);
        rst_n = 1'b1;
        bus_addr = 1'b0;
        // R1: all inputs, nothing driven, pad read back
        expect_at(K_RDATA, 8'hFF, 1, "R1");
        expect_at(K_OE,    8'h00, 1, "R1");
        expect_at(K_PU,    8'h0F, 1, "R7");
        idle(2);

        // R2: low nibble becomes outputs
        bus_write(1'b1, 8'hF0);
        bus_addr = 1'b1;
        expect_at(K_RDATA, 8'hF0, 1, "R2");
        expect_at(K_OE,    8'h0F, 1, "R5");
        expect_at(K_PU,    8'h00, 1, "R7");
        idle(2);

        // R2 / R4: latch write, low nibble read from latch
        bus_write(1'b0, 8'hA5);
        expect_at(K_RDATA, 8'hF5, 1, "R4");
        expect_at(K_OUT,   8'hA5, 1, "R5");
        idle(2);

        // R3 / R8: input nibble falls
        pad_in = 8'h0A;
        expect_at(K_RDATA, 8'hF5, 1, "R3");
        expect_at(K_WAKE,  8'h00, 1, "R8");
        expect_at(K_RDATA, 8'h05, 2, "R3");
        expect_at(K_WAKE,  8'h01, 2, "R8");
        expect_at(K_WAKE,  8'h00, 3, "R8");
        idle(4);

        // R4 / R8: output pins change at the pad: no read change, no wake
        pad_in = 8'h05;
        expect_at(K_WAKE,  8'h00, 2, "R8");
        expect_at(K_RDATA, 8'h05, 2, "R4");
        expect_at(K_WAKE,  8'h00, 3, "R8");
        idle(4);

        // R9: data on the bus without a strobe
        bus_addr = 1'b0; bus_wdata = 8'h00;
        expect_at(K_OUT,   8'hA5, 2, "R9");
        idle(1);
        bus_addr = 1'b1;
        expect_at(K_RDATA, 8'hF0, 2, "R9");
        idle(3);

        // R6: open-drain drives low only where the latch is 0
        od_cfg = 8'hFF;
        expect_at(K_OUT, 8'h00, 1, "R6");
        expect_at(K_OE,  8'h0A, 1, "R6");
        idle(2);

        // R7: pull-up allowed everywhere, only inputs get it
        pu_cfg = 8'hFF;
        expect_at(K_PU, 8'hF0, 1, "R7");
        idle(2);

        // R1: reset again restores all ones
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        bus_addr = 1'b1;
        expect_at(K_RDATA, 8'hFF, 1, "R1");
        expect_at(K_OE,    8'h00, 1, "R1");
        idle(3);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule